// File: doc/BRIEF.md
# Channel Code Gain and Offset Trim Pipeline

This block sits between a channel's code register and its converter core. It takes a raw code and first maps it to a signed value centred on mid-scale. A coding-select input tells it whether the raw code is offset binary or two's complement. It then adds a small proportional gain correction and a sub-LSB offset correction. Both corrections are carried with three fractional bits. The sum is rounded to a whole code and brought back to offset binary. Any result outside the code range is clamped and flagged.

Each channel has its own copy of the block. A 6-bit signed gain trim moves the full-scale code by up to -32 or +31 LSB and leaves mid-scale where it is. An 8-bit signed offset trim shifts every code in eighth-LSB steps. The pipeline accepts one code per cycle and marks each input with a valid strobe. The matching result appears exactly two cycles later. A narrower-resolution build ignores the unused low bits of the code.

Top module: `code_trim_pipe`

## Requirements
- R1: With `coding_sel`=1 the input is offset binary (0x8000 is mid-scale, 0x0000 is negative full scale). With `coding_sel`=0 it is two's complement (0x0000 is mid-scale, 0x8000 is negative full scale). With both trims zero, `out_code` is the offset-binary form of the input: the input itself in offset-binary mode, or the input with bit 15 inverted in two's-complement mode.
- R2: Let s be the offset-binary code minus 32768, and g the signed value of `gain_trim`. The gain correction, in eighths of an LSB, is floor(s*g/4096). Mid-scale (s=0) is therefore unchanged for every g, and g=0 has no effect.
- R3: `offset_trim` is a signed 8-bit value in eighths of an LSB (range -16 to +15.875 LSB) and is added to the sum.
- R4: The sum in eighths, acc = 8*s + gain correction + offset, is rounded to floor((acc+4)/8). An exact half therefore rounds upward. The result is r + 32768.
- R5: A result below 0 gives 0x0000 and a result above 0xFFFF gives 0xFFFF, and in both cases `out_ovf` is 1. `out_ovf` is 1 only in a cycle where `out_valid` is 1.
- R6: `out_valid` equals `in_valid` delayed by exactly two clock cycles. The result of an input is on `out_code` and `out_ovf` in that cycle. While `out_valid` is 0, `out_code` keeps its last value and `out_ovf` is 0.
- R7: A cycle of synchronous `rst` leaves `out_valid`=0, `out_ovf`=0 and `out_code`=0x8000.
- R8: With parameter RES_W below 16, the low 16-RES_W bits of `in_code` are taken as zero. With RES_W=14, bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input code strobe |
| in_code | input | 16 | Raw channel code |
| coding_sel | input | 1 | 1 = offset binary, 0 = two's complement |
| gain_trim | input | 6 | Signed full-scale trim, 1 LSB steps |
| offset_trim | input | 8 | Signed offset trim, 1/8 LSB steps |
| out_valid | output | 1 | Result strobe |
| out_code | output | 16 | Corrected offset-binary code |
| out_ovf | output | 1 | Saturation flag for the current result |

## Verification
An input sampled on one rising edge loads the first stage at that edge. The output register takes the result on the next rising edge. So `out_valid`, `out_code` and `out_ovf` for that input are due two edges after it was applied. The bench drives inputs on falling edges and keeps a two-entry delay line of expected results. On each falling edge it compares the outputs with the entry that is now two edges old. In cycles with no result due, it checks that the code holds and that the flag is clear. A second instance built with 14-bit resolution gets the same stimulus and is checked against its own model.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic {
    CODING_TWOS   = 1'b0,
    CODING_OFFSET = 1'b1
  } coding_e;
endpackage

// File: rtl/code_normalize.sv
module code_normalize #(
  parameter int CODE_W = 16,
  parameter int RES_W  = 16
) (
  input  logic                     coding_sel,
  input  logic [CODE_W-1:0]        raw,
  output logic signed [CODE_W:0]   centered
);
  import trim_pkg::*;
  localparam int DROP_W = CODE_W - RES_W;

  logic [CODE_W-1:0] masked;
  logic [CODE_W-1:0] ob_code;

  generate
    if (DROP_W > 0) begin : g_narrow
      assign masked = {raw[CODE_W-1:DROP_W], {DROP_W{1'b0}}};
    end else begin : g_full
      assign masked = raw;
    end
  endgenerate

  // Bring both codings to offset binary, then subtract mid-scale by
  // flipping the MSB and sign-extending.
  always_comb begin
    if (coding_sel == CODING_OFFSET) ob_code = masked;
    else ob_code = {~masked[CODE_W-1], masked[CODE_W-2:0]};
    centered = {~ob_code[CODE_W-1], ~ob_code[CODE_W-1], ob_code[CODE_W-2:0]};
  end
endmodule

// File: rtl/trim_mult_stage.sv
module trim_mult_stage #(
  parameter int CODE_W = 16,
  parameter int GAIN_W = 6,
  parameter int OFS_W  = 8,
  parameter int FRAC_W = 3,
  parameter int ACC_W  = CODE_W + FRAC_W + 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [CODE_W:0]   centered,
  input  logic [GAIN_W-1:0]        gain_trim,
  input  logic [OFS_W-1:0]         offset_trim,
  output logic                     s1_valid,
  output logic signed [ACC_W-1:0]  base,
  output logic signed [ACC_W-1:0]  corr
);
  localparam int PROD_W = CODE_W + 1 + GAIN_W;
  localparam int SHIFT  = CODE_W - 1 - FRAC_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] prod_sh;
  logic signed [ACC_W-1:0]  base_d;

  always_comb begin
    prod    = centered * $signed(gain_trim);
    prod_sh = prod >>> SHIFT;
    base_d  = (ACC_W'(centered) <<< FRAC_W) + ACC_W'($signed(offset_trim));
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    if (in_valid) begin
      base <= base_d;
      corr <= ACC_W'(prod_sh);
    end
  end
endmodule

// File: rtl/round_sat_stage.sv
module round_sat_stage #(
  parameter int CODE_W = 16,
  parameter int FRAC_W = 3,
  parameter int ACC_W  = CODE_W + FRAC_W + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s1_valid,
  input  logic signed [ACC_W-1:0] base,
  input  logic signed [ACC_W-1:0] corr,
  output logic                    out_valid,
  output logic [CODE_W-1:0]       out_code,
  output logic                    out_ovf
);
  localparam logic signed [ACC_W-1:0] HALF_C = ACC_W'(1 << (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] MID_C  = ACC_W'(1 << (CODE_W - 1));
  localparam logic signed [ACC_W-1:0] MAX_C  = ACC_W'((1 << CODE_W) - 1);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] rnd;
  logic signed [ACC_W-1:0] biased;
  logic [CODE_W-1:0]       sat_code;
  logic                    sat_hit;

  always_comb begin
    acc    = base + corr;
    rnd    = (acc + HALF_C) >>> FRAC_W;
    biased = rnd + MID_C;
    if (biased < 0) begin
      sat_code = '0;
      sat_hit  = 1'b1;
    end else if (biased > MAX_C) begin
      sat_code = '1;
      sat_hit  = 1'b1;
    end else begin
      sat_code = biased[CODE_W-1:0];
      sat_hit  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ovf   <= 1'b0;
      out_code  <= MID_C[CODE_W-1:0];
    end else begin
      out_valid <= s1_valid;
      out_ovf   <= s1_valid & sat_hit;
      if (s1_valid) out_code <= sat_code;
    end
  end
endmodule

// File: rtl/code_trim_pipe.sv
module code_trim_pipe #(
  parameter int CODE_W = 16,
  parameter int RES_W  = 16,
  parameter int GAIN_W = 6,
  parameter int OFS_W  = 8,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              coding_sel,
  input  logic [GAIN_W-1:0] gain_trim,
  input  logic [OFS_W-1:0]  offset_trim,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_ovf
);
  localparam int ACC_W = CODE_W + FRAC_W + 3;

  logic signed [CODE_W:0]  centered;
  logic                    s1_valid;
  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W-1:0] corr;

  code_normalize #(.CODE_W(CODE_W), .RES_W(RES_W)) i_norm (
    .coding_sel(coding_sel), .raw(in_code), .centered(centered)
  );

  trim_mult_stage #(
    .CODE_W(CODE_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W),
    .FRAC_W(FRAC_W), .ACC_W(ACC_W)
  ) i_mult (
    .clk(clk), .rst(rst), .in_valid(in_valid), .centered(centered),
    .gain_trim(gain_trim), .offset_trim(offset_trim),
    .s1_valid(s1_valid), .base(base), .corr(corr)
  );

  round_sat_stage #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) i_rsat (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .base(base), .corr(corr),
    .out_valid(out_valid), .out_code(out_code), .out_ovf(out_ovf)
  );
endmodule

// File: rtl/code_trim_pipe_chk.sv
module code_trim_pipe_chk #(
  parameter int CODE_W = 16,
  parameter int RES_W  = 16,
  parameter int GAIN_W = 6,
  parameter int OFS_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [CODE_W-1:0] in_code,
  input logic              coding_sel,
  input logic [GAIN_W-1:0] gain_trim,
  input logic [OFS_W-1:0]  offset_trim,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_code,
  input logic              out_ovf
);
  localparam int DROP_W = CODE_W - RES_W;
  localparam logic [CODE_W-1:0] LOW_MASK = CODE_W'((1 << DROP_W) - 1);
  localparam logic [CODE_W-1:0] MSB_BIT  = CODE_W'(1 << (CODE_W - 1));

  logic [CODE_W-1:0] plain_code;
  logic              zero_trim;

  always_comb begin
    plain_code = (in_code & ~LOW_MASK) ^ (coding_sel ? '0 : MSB_BIT);
    zero_trim  = in_valid && (gain_trim == '0) && (offset_trim == '0);
  end

  // R1 R8
  passthrough_chk: assert property (@(posedge clk) disable iff (rst)
    zero_trim |-> ##2 (out_valid && out_code == $past(plain_code, 2)));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_valid && (out_code == '0 || out_code == '1)));

  // R6
  latency_on_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R6
  latency_off_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 (!out_valid && !out_ovf && $stable(out_code)));

  // R7
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_ovf && out_code == MSB_BIT));
endmodule

bind code_trim_pipe code_trim_pipe_chk #(
  .CODE_W(CODE_W), .RES_W(RES_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W)
) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
  .coding_sel(coding_sel), .gain_trim(gain_trim), .offset_trim(offset_trim),
  .out_valid(out_valid), .out_code(out_code), .out_ovf(out_ovf)
);

// File: tb/test_code_trim_pipe.sv
module test_code_trim_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_code = '0;
  logic        coding_sel = 1'b1;
  logic [5:0]  gain_trim = '0;
  logic [7:0]  offset_trim = '0;
  logic        ov16, ov14, of16, of14;
  logic [15:0] oc16, oc14;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic        p_val [2];
  logic [15:0] p_c16 [2];
  logic        p_f16 [2];
  logic [15:0] p_c14 [2];
  logic        p_f14 [2];
  string       p_tag [2];
  logic [15:0] hold16 = 16'h8000;
  logic [15:0] hold14 = 16'h8000;

  always #5 clk = ~clk;

  code_trim_pipe i_code_trim_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .coding_sel(coding_sel), .gain_trim(gain_trim), .offset_trim(offset_trim),
    .out_valid(ov16), .out_code(oc16), .out_ovf(of16)
  );

  code_trim_pipe #(.RES_W(14)) i_code_trim_pipe_r14 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .coding_sel(coding_sel), .gain_trim(gain_trim), .offset_trim(offset_trim),
    .out_valid(ov14), .out_code(oc14), .out_ovf(of14)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Model built from the requirement formulas.
  task automatic model(input logic [15:0] raw, input logic [5:0] g,
                       input logic [7:0] o, input logic ob, input int res,
                       output logic [15:0] code, output logic ovf);
    int s, corr, acc, r, v;
    logic [15:0] m, u;
    m = raw & ~16'((1 << (16 - res)) - 1);
    u = ob ? m : (m ^ 16'h8000);
    s = int'(u) - 32768;
    corr = (s * int'($signed(g))) >>> 12;
    acc = s * 8 + corr + int'($signed(o));
    r = (acc + 4) >>> 3;
    v = r + 32768;
    ovf = (v < 0) || (v > 65535);
    code = (v < 0) ? 16'h0000 : (v > 65535) ? 16'hFFFF : 16'(v);
  endtask

  task automatic step(input logic v, input logic [15:0] raw, input logic [5:0] g,
                      input logic [7:0] o, input logic ob, input string tag);
    logic [15:0] c16, c14;
    logic f16, f14;
    @(negedge clk);
    check("R6 valid", int'(ov16), int'(p_val[1]));
    check("R6 valid r14", int'(ov14), int'(p_val[1]));
    if (p_val[1]) begin
      check({p_tag[1], " code"}, int'(oc16), int'(p_c16[1]));
      check({p_tag[1], " R5 ovf"}, int'(of16), int'(p_f16[1]));
      check({p_tag[1], " R8 code r14"}, int'(oc14), int'(p_c14[1]));
      check({p_tag[1], " R5 ovf r14"}, int'(of14), int'(p_f14[1]));
      hold16 = p_c16[1];
      hold14 = p_c14[1];
    end else begin
      check("R6 hold", int'(oc16), int'(hold16));
      check("R5 ovf idle", int'(of16), 0);
      check("R6 hold r14", int'(oc14), int'(hold14));
    end
    p_val[1] = p_val[0]; p_c16[1] = p_c16[0]; p_f16[1] = p_f16[0];
    p_c14[1] = p_c14[0]; p_f14[1] = p_f14[0]; p_tag[1] = p_tag[0];
    model(raw, g, o, ob, 16, c16, f16);
    model(raw, g, o, ob, 14, c14, f14);
    p_val[0] = v; p_c16[0] = c16; p_f16[0] = f16;
    p_c14[0] = c14; p_f14[0] = f14; p_tag[0] = tag;
    in_valid = v; in_code = raw; gain_trim = g; offset_trim = o; coding_sel = ob;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      p_val[i] = 0; p_c16[i] = 0; p_f16[i] = 0; p_c14[i] = 0; p_f14[i] = 0;
      p_tag[i] = "";
    end
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7: state left by reset
    check("R7 valid", int'(ov16), 0);
    check("R7 ovf", int'(of16), 0);
    check("R7 code", int'(oc16), 16'h8000);

    // Directed corners
    step(1, 16'h8000, 6'd0, 8'd0, 1, "R1 ob mid");
    step(1, 16'h0000, 6'd0, 8'd0, 0, "R1 twos mid");
    step(1, 16'h8000, 6'd0, 8'd0, 0, "R1 twos negfs");
    step(1, 16'h1234, 6'd0, 8'd0, 1, "R1 ob plain");
    step(1, 16'h8000, 6'h20, 8'd0, 1, "R2 mid gain -32");
    step(1, 16'h8000, 6'h1F, 8'd0, 1, "R2 mid gain +31");
    step(1, 16'hC000, 6'h1F, 8'd0, 1, "R2 gain +31 qtr");
    step(1, 16'h8000, 6'd0, 8'd3, 1, "R4 below half");
    step(1, 16'h8000, 6'd0, 8'd4, 1, "R4 half up");
    step(1, 16'h8000, 6'd0, 8'hFC, 1, "R4 neg half");
    step(1, 16'h8000, 6'd0, 8'hFB, 1, "R3 neg offset");
    step(1, 16'h8000, 6'd0, 8'h7F, 1, "R3 max offset");
    step(1, 16'hFFFF, 6'h1F, 8'd0, 1, "R5 top sat");
    step(0, 16'h0000, 6'd0, 8'd0, 1, "R6 gap");
    step(1, 16'h0000, 6'h1F, 8'd0, 1, "R5 bottom sat");
    step(1, 16'hFFFF, 6'd0, 8'h7F, 1, "R5 offset sat");
    step(1, 16'h8003, 6'd0, 8'd0, 1, "R8 low bits");
    step(1, 16'h7FFF, 6'd0, 8'd0, 0, "R1 twos posfs");

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] raw;
      int sel;
      sel = $urandom_range(0, 7);
      raw = (sel == 0) ? 16'hFFFF : (sel == 1) ? 16'h0000 : 16'($urandom);
      step($urandom_range(0, 3) != 0, raw, 6'($urandom), 8'($urandom),
           1'($urandom), "R2 R3 R4 R5 random");
    end
    step(0, 16'h0, 6'd0, 8'd0, 1, "R6 flush");
    step(0, 16'h0, 6'd0, 8'd0, 1, "R6 flush");
    step(0, 16'h0, 6'd0, 8'd0, 1, "R6 flush");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule